// File: doc/BRIEF.md
# Two-Level Interrupt Status Aggregator

This block gathers interrupt events from the link side of a host bridge into two first-level status registers. Each register has its own mask. The unmasked contents of both registers fold into a single summary bit held in a top-level status register. The top-level register has its own mask, and its unmasked contents drive one level-sensitive interrupt line toward the processor.

Events arrive as single-cycle pulses:
- legacy interrupts A to D, asserted and deasserted
- message-signalled interrupt pending
- power-management event message
- power state change
- flush

Every status bit is sticky and is cleared by writing 1 to it. Software reads and writes the six registers through a simple 32-bit register port. The port has a write strobe and a combinational read.

In a service routine, software first reads the summary register. It then reads the two first-level registers, clears the bits it has handled, and finally clears the summary bit. If any source is still active at that point, the summary bit sets again on the next cycle, so no event is lost.

Top module: `irq_aggregator`

## Requirements
- R1: A pulse on legacy assert n (n = 0..3) sets bit 16+n of status A and bit 8+n of status B. A pulse on legacy deassert n sets bit 20+n of status A.
- R2: A message-interrupt-pending pulse sets bit 24 of status A. A power-management message pulse sets bit 7 of status A.
- R3: A power-state-change pulse sets bit 4 of status B. A flush pulse sets bit 5 of status B.
- R4: Status bits stay set until software writes 1 to them. Writing 0 leaves them unchanged. Bits outside the valid fields always read 0. The valid fields are status A [26:0], status B [11:4] and summary bit 16.
- R5: A mask bit of 1 blocks its status bit and 0 passes it. A level is active when some valid status bit is set and its mask bit is clear. A fully masked level never sets the summary bit.
- R6: Summary bit 16 sets on the clock edge after either level is active. It is cleared by writing 1, and it sets again on that same edge if a level is still active.
- R7: When an event pulse and a write-1 clear of the same bit occur in the same cycle, the bit remains set.
- R8: `irq_out` is high exactly while summary bit 16 is set and summary mask bit 16 is clear.
- R9: After reset, every status register reads 0, every mask register reads 0xFFFFFFFF and `irq_out` is low.
- R10: The register addresses are:

  | Address | Register |
  |---|---|
  | 0 | status A |
  | 1 | mask A |
  | 2 | status B |
  | 3 | mask B |
  | 4 | summary status |
  | 5 | summary mask |

  Reads of addresses 6 and 7 return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_intx_on | input | 4 | Legacy interrupt assert pulses, one bit per line A..D |
| ev_intx_off | input | 4 | Legacy interrupt deassert pulses |
| ev_msi | input | 1 | Message interrupt pending pulse |
| ev_pme | input | 1 | Power-management message pulse |
| ev_pwr | input | 1 | Power state change pulse |
| ev_flush | input | 1 | Flush pulse |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 3 | Write address |
| reg_wdata | input | 32 | Write data |
| reg_raddr | input | 3 | Read address |
| reg_rdata | output | 32 | Read data, combinational |
| irq_out | output | 1 | Level interrupt to the processor |

## Verification
The assertions check the following on every cycle:
- each event reaches its status bit on the next edge;
- a bit is never lost without a clearing write;
- a set beats a clear when both occur together;
- an active level raises the summary bit;
- the interrupt line only rises when the summary bit is set.

Only the bench's scenarios can show the rest:
- that the exact bit positions read back through the register port;
- that masked levels stay silent;
- the full clear-and-reassert service sequence;
- the reset values and the unmapped addresses.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
    localparam int DW       = 32;
    localparam int AW       = 3;
    localparam int NUM_INTX = 4;

    localparam logic [AW-1:0] A_STAT_A = 3'd0;
    localparam logic [AW-1:0] A_MASK_A = 3'd1;
    localparam logic [AW-1:0] A_STAT_B = 3'd2;
    localparam logic [AW-1:0] A_MASK_B = 3'd3;
    localparam logic [AW-1:0] A_STAT_T = 3'd4;
    localparam logic [AW-1:0] A_MASK_T = 3'd5;

    // bit positions decoded by software
    localparam int POS_A_ON   = 16;
    localparam int POS_A_OFF  = 20;
    localparam int POS_A_MSI  = 24;
    localparam int POS_A_PME  = 7;
    localparam int POS_B_ON   = 8;
    localparam int POS_B_PWR  = 4;
    localparam int POS_B_FLSH = 5;
    localparam int POS_T_CORE = 16;

    localparam logic [DW-1:0] VALID_A = 32'h07FF_FFFF;
    localparam logic [DW-1:0] VALID_B = 32'h0000_0FF0;
    localparam logic [DW-1:0] VALID_T = 32'h0001_0000;
    localparam logic [DW-1:0] SRC_T   = 32'h00FF_F0FB;
endpackage

// File: rtl/irq_stat_cell.sv
module irq_stat_cell #(
    parameter int              W     = 32,
    parameter logic [W-1:0]    VALID = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_vec,
    input  logic         stat_we,
    input  logic         mask_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] stat_q,
    output logic [W-1:0] mask_q,
    output logic         active
);
    logic [W-1:0] clr_vec;

    always_comb begin
        clr_vec = stat_we ? wdata : '0;
        active  = |(stat_q & ~mask_q & VALID);
    end

    // set has priority over a same-cycle clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
            mask_q <= '1;
        end else begin
            stat_q <= ((stat_q & ~clr_vec) | set_vec) & VALID;
            if (mask_we)
                mask_q <= wdata;
        end
    end
endmodule

// File: rtl/irq_agg_regmux.sv
module irq_agg_regmux
    import irq_agg_pkg::*;
(
    input  logic [AW-1:0] raddr,
    input  logic [DW-1:0] stat_a,
    input  logic [DW-1:0] mask_a,
    input  logic [DW-1:0] stat_b,
    input  logic [DW-1:0] mask_b,
    input  logic [DW-1:0] stat_t,
    input  logic [DW-1:0] mask_t,
    output logic [DW-1:0] rdata
);
    always_comb begin
        unique case (raddr)
            A_STAT_A: rdata = stat_a;
            A_MASK_A: rdata = mask_a;
            A_STAT_B: rdata = stat_b;
            A_MASK_B: rdata = mask_b;
            A_STAT_T: rdata = stat_t;
            A_MASK_T: rdata = mask_t;
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irq_agg_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_INTX-1:0] ev_intx_on,
    input  logic [NUM_INTX-1:0] ev_intx_off,
    input  logic                ev_msi,
    input  logic                ev_pme,
    input  logic                ev_pwr,
    input  logic                ev_flush,
    input  logic                reg_we,
    input  logic [AW-1:0]       reg_waddr,
    input  logic [DW-1:0]       reg_wdata,
    input  logic [AW-1:0]       reg_raddr,
    output logic [DW-1:0]       reg_rdata,
    output logic                irq_out
);
    logic [DW-1:0] set_a, set_b, set_t;
    logic [DW-1:0] stat_a_q, mask_a_q, stat_b_q, mask_b_q, stat_t_q, mask_t_q;
    logic          act_a, act_b, act_lvl, act_t;
    logic          we_sa, we_ma, we_sb, we_mb, we_st, we_mt;

    always_comb begin
        we_sa = reg_we && (reg_waddr == A_STAT_A);
        we_ma = reg_we && (reg_waddr == A_MASK_A);
        we_sb = reg_we && (reg_waddr == A_STAT_B);
        we_mb = reg_we && (reg_waddr == A_MASK_B);
        we_st = reg_we && (reg_waddr == A_STAT_T);
        we_mt = reg_we && (reg_waddr == A_MASK_T);
    end

    always_comb begin
        set_a = '0;
        set_b = '0;
        for (int n = 0; n < NUM_INTX; n++) begin
            set_a[POS_A_ON + n]  = ev_intx_on[n];
            set_a[POS_A_OFF + n] = ev_intx_off[n];
            set_b[POS_B_ON + n]  = ev_intx_on[n];
        end
        set_a[POS_A_MSI]  = ev_msi;
        set_a[POS_A_PME]  = ev_pme;
        set_b[POS_B_PWR]  = ev_pwr;
        set_b[POS_B_FLSH] = ev_flush;
        act_lvl = act_a | act_b;
        set_t   = '0;
        set_t[POS_T_CORE] = act_lvl;
    end

    irq_stat_cell #(.W(DW), .VALID(VALID_A)) u_lvl_a (
        .clk(clk), .rst_n(rst_n), .set_vec(set_a), .stat_we(we_sa),
        .mask_we(we_ma), .wdata(reg_wdata), .stat_q(stat_a_q),
        .mask_q(mask_a_q), .active(act_a));

    irq_stat_cell #(.W(DW), .VALID(VALID_B)) u_lvl_b (
        .clk(clk), .rst_n(rst_n), .set_vec(set_b), .stat_we(we_sb),
        .mask_we(we_mb), .wdata(reg_wdata), .stat_q(stat_b_q),
        .mask_q(mask_b_q), .active(act_b));

    irq_stat_cell #(.W(DW), .VALID(VALID_T & SRC_T)) u_lvl_t (
        .clk(clk), .rst_n(rst_n), .set_vec(set_t), .stat_we(we_st),
        .mask_we(we_mt), .wdata(reg_wdata), .stat_q(stat_t_q),
        .mask_q(mask_t_q), .active(act_t));

    irq_agg_regmux u_mux (
        .raddr(reg_raddr), .stat_a(stat_a_q), .mask_a(mask_a_q),
        .stat_b(stat_b_q), .mask_b(mask_b_q), .stat_t(stat_t_q),
        .mask_t(mask_t_q), .rdata(reg_rdata));

    assign irq_out = act_t;
endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk
    import irq_agg_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_INTX-1:0] ev_intx_on,
    input logic                ev_msi,
    input logic                ev_pme,
    input logic                ev_pwr,
    input logic                reg_we,
    input logic [AW-1:0]       reg_waddr,
    input logic [DW-1:0]       reg_wdata,
    input logic [DW-1:0]       stat_a,
    input logic [DW-1:0]       stat_b,
    input logic [DW-1:0]       stat_t,
    input logic                act_lvl,
    input logic                irq_out
);
    assert_on_to_b_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_intx_on != '0) |=> ((stat_b[11:8] & $past(ev_intx_on)) == $past(ev_intx_on)));

    assert_msi_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ev_msi |=> stat_a[POS_A_MSI]);

    assert_pwr_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ev_pwr |=> stat_b[POS_B_PWR]);

    assert_sticky_a_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && reg_waddr == A_STAT_A) |=> ((stat_a & $past(stat_a)) == $past(stat_a)));

    assert_summary_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        act_lvl |=> stat_t[POS_T_CORE]);

    assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_pme && reg_we && reg_waddr == A_STAT_A && reg_wdata[POS_A_PME]) |=> stat_a[POS_A_PME]);

    assert_irq_needs_core_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> stat_t[POS_T_CORE]);

    assert_invalid_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_a & ~VALID_A) == '0) && ((stat_b & ~VALID_B) == '0));
endmodule

bind irq_aggregator irq_agg_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ev_intx_on(ev_intx_on), .ev_msi(ev_msi),
    .ev_pme(ev_pme), .ev_pwr(ev_pwr), .reg_we(reg_we), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .stat_a(stat_a_q), .stat_b(stat_b_q),
    .stat_t(stat_t_q), .act_lvl(act_lvl), .irq_out(irq_out));

// File: tb/irq_aggregator_bench.sv
module irq_aggregator_bench;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [3:0]  ev_on = 0, ev_off = 0;
    logic        ev_msi = 0, ev_pme = 0, ev_pwr = 0, ev_flush = 0;
    logic        we = 0;
    logic [2:0]  waddr = 0, raddr = 0;
    logic [31:0] wdata = 0, rdata;
    logic        irq;
    int          n_run = 0, n_fail = 0;
    bit          done = 0;

    always #4 clk = ~clk;   // 125 MHz

    irq_aggregator u_irq_aggregator (
        .clk(clk), .rst_n(rst_n), .ev_intx_on(ev_on), .ev_intx_off(ev_off),
        .ev_msi(ev_msi), .ev_pme(ev_pme), .ev_pwr(ev_pwr), .ev_flush(ev_flush),
        .reg_we(we), .reg_waddr(waddr), .reg_wdata(wdata),
        .reg_raddr(raddr), .reg_rdata(rdata), .irq_out(irq));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        raddr = a; #1; d = rdata;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); we = 1; waddr = a; wdata = d;
        @(negedge clk); we = 0;
    endtask

    task automatic drive(input int e, input logic v);
        if (e < 4) ev_on[e] = v;
        else if (e < 8) ev_off[e-4] = v;
        else if (e == 8) ev_msi = v;
        else if (e == 9) ev_pme = v;
        else if (e == 10) ev_pwr = v;
        else ev_flush = v;
    endtask

    task automatic fire(input int e);
        @(negedge clk); drive(e, 1);
        @(negedge clk); drive(e, 0);
    endtask

    function automatic logic [31:0] exp_a(input int e);
        if (e < 4) return 32'h1 << (16 + e);
        if (e < 8) return 32'h1 << (20 + e - 4);
        if (e == 8) return 32'h1 << 24;
        if (e == 9) return 32'h1 << 7;
        return 0;
    endfunction

    function automatic logic [31:0] exp_b(input int e);
        if (e < 4) return 32'h1 << (8 + e);
        if (e == 10) return 32'h1 << 4;
        if (e == 11) return 32'h1 << 5;
        return 0;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R9 reset values
        for (int a = 0; a < 6; a++) begin
            rd(a[2:0], d);
            check("R9", d, (a % 2 == 1) ? 32'hFFFF_FFFF : 32'h0);
        end
        check("R9 irq", {31'b0, irq}, 0);

        // R1 R2 R3 R5: every event with all masks set
        for (int e = 0; e < 12; e++) begin
            fire(e);
            @(negedge clk);
            rd(0, d); check("R1/R2 status A", d, exp_a(e));
            rd(2, d); check("R1/R3 status B", d, exp_b(e));
            rd(4, d); check("R5 masked summary", d, 0);
            check("R5 masked irq", {31'b0, irq}, 0);
            wr(0, 32'hFFFF_FFFF); wr(2, 32'hFFFF_FFFF);
        end

        // R6 R8: unmask everything, sweep again with service sequence
        wr(1, 0); wr(3, 0); wr(5, ~(32'h1 << 16));
        for (int e = 0; e < 12; e++) begin
            fire(e);
            @(negedge clk);
            rd(4, d); check("R6 summary set", d, 32'h1 << 16);
            check("R8 irq high", {31'b0, irq}, 1);
            wr(4, 32'h1 << 16);      // lower still active -> re-set
            rd(4, d); check("R6 summary re-set", d, 32'h1 << 16);
            wr(0, exp_a(e)); wr(2, exp_b(e));
            wr(4, 32'h1 << 16);
            rd(4, d); check("R6 summary cleared", d, 0);
            check("R8 irq low", {31'b0, irq}, 0);
        end

        // R4: write 0 no effect, partial clear, invalid bits
        fire(8); fire(9);
        wr(0, 0);
        rd(0, d); check("R4 write0", d, (32'h1 << 24) | (32'h1 << 7));
        wr(0, 32'h1 << 24);
        rd(0, d); check("R4 partial clear", d, 32'h1 << 7);
        wr(2, 32'hFFFF_FFFF);
        rd(2, d); check("R4 B invalid", d, 0);

        // R8: summary mask toggles irq
        @(negedge clk);
        check("R8 irq unmasked", {31'b0, irq}, 1);
        wr(5, 32'hFFFF_FFFF);
        check("R8 irq masked", {31'b0, irq}, 0);
        wr(5, ~(32'h1 << 16));
        check("R8 irq back", {31'b0, irq}, 1);
        // R5: mask only level A bit 7 -> level inactive, summary stays clear
        wr(1, 32'h1 << 7); wr(4, 32'h1 << 16);
        @(negedge clk);
        rd(4, d); check("R5 mask bit", d, 0);
        wr(0, 32'hFFFF_FFFF); wr(1, 0);

        // R7: event and clear of the same bit together
        @(negedge clk); ev_pme = 1; we = 1; waddr = 0; wdata = 32'h1 << 7;
        @(negedge clk); ev_pme = 0; we = 0;
        rd(0, d); check("R7 set wins", d, 32'h1 << 7);
        wr(0, 32'hFFFF_FFFF);
        rd(0, d); check("R7 then clears", d, 0);

        // R10: unmapped addresses
        wr(6, 32'hFFFF_FFFF); wr(7, 32'h0);
        rd(6, d); check("R10 read 6", d, 0);
        rd(7, d); check("R10 read 7", d, 0);
        rd(1, d); check("R10 mask A untouched", d, 0);
        rd(5, d); check("R10 mask T untouched", d, ~(32'h1 << 16));

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule